// File: doc/BRIEF.md
# Interrupt source gatherer with memory-mapped registers

This peripheral sits between a set of device interrupt sources and a processor that has two interrupt inputs: an ordinary one and a fast one. The device lines arrive in three groups of up to eight. Two ordinary groups, called A and B, share the processor's ordinary interrupt output. A third, fast group drives the fast output on its own. For each group, software can read the raw state of the sources and the state after masking. It can also read and write an enable mask.

The low four sources of group A are treated as events. A rising edge sets a sticky bit, and that bit stays set until software writes a one to the clear address. Every other source is level-sensitive and simply follows its input. Access is through a plain synchronous register port. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address. Two further storage registers, for control and keyboard data, sit at the bottom of the map.

Top module: `intr_mux_regs`

## Requirements
- R1: After reset all masks, the control and keyboard registers and the sticky bits of group A are zero, and both `irq` and `fiq` are low.
- R2: Reading 0x10 returns the status of group A: bits 7..4 are the live source levels and bits 3..0 are the sticky bits. Reading 0x20 and 0x30 returns the live source levels of group B and of the fast group.
- R3: Reading 0x14, 0x24 and 0x34 returns the request of group A, B and the fast group respectively. Each request is the bitwise AND of that group's status and mask.
- R4: The masks of A, B and the fast group can be read and written at 0x18, 0x28 and 0x38.
- R5: `irq` is high exactly when any request bit of group A or group B is set. `fiq` is high exactly when any request bit of the fast group is set.
- R6: A rising edge on `src_a[3:0]` sets the matching sticky bit. The bit can be read from the clock edge that samples the source high, and it stays set after the source falls.
- R7: Writing to 0x14 clears each sticky bit whose write-data bit is 1. Sticky bits whose write-data bit is 0 are left alone. If a rising edge of the same bit arrives in that cycle, the bit stays set.
- R8: The control register at 0x00 and the keyboard register at 0x04 are 8-bit read/write storage.
- R9: Offsets with no register (0x08, 0x0C, 0x1C, 0x2C, 0x3C) read as zero, and writes to them change no register.
- R10: Writes to the read-only addresses (0x10, 0x20, 0x24, 0x30, 0x34) change no register. A write to 0x14 changes only the sticky bits and leaves the level bits and the masks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| src_a | input | 8 | Group A sources (bits 3..0 edge, 7..4 level) |
| src_b | input | 8 | Group B sources, level |
| src_f | input | 8 | Fast group sources, level |
| irq | output | 1 | Ordinary interrupt to the processor |
| fiq | output | 1 | Fast interrupt to the processor |

## Verification
The bench goes after the sticky bits. It checks that a bit survives the fall of its source, where a design that stored the level instead would drop it. It checks that a partial clear removes only the selected bits, where a wrong decode would clear the whole nibble. It also checks the cycle in which a new edge meets a clear, where a design that gave the clear priority would lose the event. It writes to every unused and read-only address and then reads the masks back, so an aliased decode would show up as a corrupted register. It also checks that a mask on one group never raises the other group's output line.

// File: rtl/intr_mux_regs.sv
module intr_mux_regs #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int EDGE_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_f,
  output logic              irq,
  output logic              fiq
);

  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] OFS_KBD   = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] OFS_A_ST  = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] OFS_A_RQ  = ADDR_W'(6'h14);
  localparam logic [ADDR_W-1:0] OFS_A_MK  = ADDR_W'(6'h18);
  localparam logic [ADDR_W-1:0] OFS_B_ST  = ADDR_W'(6'h20);
  localparam logic [ADDR_W-1:0] OFS_B_RQ  = ADDR_W'(6'h24);
  localparam logic [ADDR_W-1:0] OFS_B_MK  = ADDR_W'(6'h28);
  localparam logic [ADDR_W-1:0] OFS_F_ST  = ADDR_W'(6'h30);
  localparam logic [ADDR_W-1:0] OFS_F_RQ  = ADDR_W'(6'h34);
  localparam logic [ADDR_W-1:0] OFS_F_MK  = ADDR_W'(6'h38);

  logic [DATA_W-1:0] ctrl_q, kbd_q, mask_a, mask_b, mask_f;
  logic [EDGE_N-1:0] lat_q, prev_q;

  wire [DATA_W-1:0] stat_a = {src_a[DATA_W-1:EDGE_N], lat_q};
  wire [DATA_W-1:0] req_a  = stat_a & mask_a;
  wire [DATA_W-1:0] req_b  = src_b & mask_b;
  wire [DATA_W-1:0] req_f  = src_f & mask_f;

  wire              clr_wr = wr_en && (addr == OFS_A_RQ);
  wire [EDGE_N-1:0] rise   = src_a[EDGE_N-1:0] & ~prev_q;
  wire [EDGE_N-1:0] clr    = {EDGE_N{clr_wr}} & wdata[EDGE_N-1:0];

  assign irq = |{req_a, req_b};
  assign fiq = |req_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= src_a[EDGE_N-1:0];
      lat_q  <= (lat_q & ~clr) | rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      kbd_q  <= '0;
      mask_a <= '0;
      mask_b <= '0;
      mask_f <= '0;
    end else if (wr_en) begin
      if (addr == OFS_CTRL) ctrl_q <= wdata;
      if (addr == OFS_KBD)  kbd_q  <= wdata;
      if (addr == OFS_A_MK) mask_a <= wdata;
      if (addr == OFS_B_MK) mask_b <= wdata;
      if (addr == OFS_F_MK) mask_f <= wdata;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rdata = ctrl_q;
      OFS_KBD:  rdata = kbd_q;
      OFS_A_ST: rdata = stat_a;
      OFS_A_RQ: rdata = req_a;
      OFS_A_MK: rdata = mask_a;
      OFS_B_ST: rdata = src_b;
      OFS_B_RQ: rdata = req_b;
      OFS_B_MK: rdata = mask_b;
      OFS_F_ST: rdata = src_f;
      OFS_F_RQ: rdata = req_f;
      OFS_F_MK: rdata = mask_f;
      default:  rdata = '0;
    endcase
  end

  // R5: the ordinary line needs an enabled ordinary group
  a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((mask_a | mask_b) != '0));

  // R5: the fast line is driven by the fast group only
  a_r5_fiq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> (mask_f != '0));

  // R6: sticky bits never drop without a clear write
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

  // R7: a same-cycle edge wins over the clear
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((lat_q & $past(rise)) == $past(rise)));

  // R7: selected bits go clear when no edge arrives with them
  a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((lat_q & $past(wdata[EDGE_N-1:0] & ~rise)) == '0));

  // R10: a clear write leaves the group A mask alone
  a_r10_clear_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> $stable(mask_a));

endmodule

// File: tb/intr_mux_regs_bench.sv
module intr_mux_regs_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [5:0] addr = '0;
  logic       wr_en = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] src_a = '0, src_b = '0, src_f = '0;
  logic       irq, fiq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_mux_regs u_intr_mux_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .src_a(src_a), .src_b(src_b), .src_f(src_f),
    .irq(irq), .fiq(fiq)
  );

  // {mask_a, src_a, mask_b, src_b, mask_f, src_f, exp_irq, exp_fiq}
  localparam logic [49:0] VEC [6] = '{
    {8'h00, 8'hF0, 8'h00, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0},
    {8'h00, 8'h00, 8'h81, 8'h80, 8'h0F, 8'hF0, 1'b1, 1'b0},
    {8'h20, 8'h20, 8'hFF, 8'h00, 8'h01, 8'h01, 1'b1, 1'b1},
    {8'h10, 8'h20, 8'h02, 8'h01, 8'h80, 8'h80, 1'b0, 1'b1},
    {8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0},
    {8'hF0, 8'hF0, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 0;
    #1 d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [5:0] idle [5] = '{6'h08, 6'h0C, 6'h1C, 6'h2C, 6'h3C};
    logic [5:0] ro [5]   = '{6'h10, 6'h20, 6'h24, 6'h30, 6'h34};
    tick(3);
    rst_n = 1;
    #1;
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 fiq", {7'b0, fiq}, 8'h00);
    rd(6'h18, d); chk("R1 mask_a", d, 8'h00);
    rd(6'h28, d); chk("R1 mask_b", d, 8'h00);
    rd(6'h38, d); chk("R1 mask_f", d, 8'h00);
    rd(6'h00, d); chk("R1 ctrl", d, 8'h00);
    rd(6'h04, d); chk("R1 kbd", d, 8'h00);
    rd(6'h10, d); chk("R1 sticky", d, 8'h00);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] ma, sa, mb, sb, mf, sf;
      {ma, sa, mb, sb, mf, sf} = VEC[i][49:2];
      wr(6'h18, ma); wr(6'h28, mb); wr(6'h38, mf);
      @(negedge clk); src_a = sa; src_b = sb; src_f = sf;
      rd(6'h18, d); chk("R4 mask_a", d, ma);
      rd(6'h28, d); chk("R4 mask_b", d, mb);
      rd(6'h38, d); chk("R4 mask_f", d, mf);
      rd(6'h10, d); chk("R2 status_a", d, sa);
      rd(6'h20, d); chk("R2 status_b", d, sb);
      rd(6'h30, d); chk("R2 status_f", d, sf);
      rd(6'h14, d); chk("R3 req_a", d, sa & ma);
      rd(6'h24, d); chk("R3 req_b", d, sb & mb);
      rd(6'h34, d); chk("R3 req_f", d, sf & mf);
      chk("R5 irq", {7'b0, irq}, {7'b0, VEC[i][1]});
      chk("R5 fiq", {7'b0, fiq}, {7'b0, VEC[i][0]});
    end

    wr(6'h18, 8'h00); wr(6'h28, 8'h00); wr(6'h38, 8'h00);
    @(negedge clk); src_a = 8'h00; src_b = 8'h00; src_f = 8'h00;

    // R6 sticky edge bits
    @(negedge clk); src_a = 8'h01;
    @(negedge clk); src_a = 8'h00;
    tick(3);
    rd(6'h10, d); chk("R6 hold after fall", d, 8'h01);
    wr(6'h18, 8'h01);
    #1 chk("R5 irq from sticky", {7'b0, irq}, 8'h01);
    rd(6'h14, d); chk("R3 req sticky", d, 8'h01);

    // R7 clear
    wr(6'h14, 8'h01);
    rd(6'h10, d); chk("R7 clear bit0", d, 8'h00);
    #1 chk("R7 irq drops", {7'b0, irq}, 8'h00);
    rd(6'h18, d); chk("R10 clear keeps mask", d, 8'h01);

    // R7 partial clear
    @(negedge clk); src_a = 8'h0C;
    @(negedge clk); src_a = 8'h00;
    rd(6'h10, d); chk("R6 bits 2,3", d, 8'h0C);
    wr(6'h14, 8'h04);
    rd(6'h10, d); chk("R7 partial clear", d, 8'h08);

    // R7 edge wins over clear
    @(negedge clk); src_a = 8'h02;
    @(negedge clk); src_a = 8'h00;
    tick(2);
    @(negedge clk); addr = 6'h14; wdata = 8'h0A; wr_en = 1; src_a = 8'h02;
    @(negedge clk); wr_en = 0;
    rd(6'h10, d); chk("R7 edge wins", d, 8'h02);

    // R10 level bit untouched by clear write
    @(negedge clk); src_a = 8'h10;
    wr(6'h14, 8'hFF);
    rd(6'h10, d); chk("R10 level bit stays", d, 8'h10);
    @(negedge clk); src_a = 8'h00;
    wr(6'h14, 8'hFF);

    // R8
    wr(6'h00, 8'hA5); wr(6'h04, 8'h3C);
    rd(6'h00, d); chk("R8 ctrl", d, 8'hA5);
    rd(6'h04, d); chk("R8 kbd", d, 8'h3C);

    // R9, R10
    wr(6'h18, 8'h11); wr(6'h28, 8'h22); wr(6'h38, 8'h44);
    for (int i = 0; i < 5; i++) begin
      wr(idle[i], 8'hFF);
      rd(idle[i], d); chk("R9 idle reads zero", d, 8'h00);
      wr(ro[i], 8'hFF);
    end
    rd(6'h18, d); chk("R10 mask_a intact", d, 8'h11);
    rd(6'h28, d); chk("R10 mask_b intact", d, 8'h22);
    rd(6'h38, d); chk("R10 mask_f intact", d, 8'h44);
    rd(6'h00, d); chk("R9 ctrl intact", d, 8'hA5);
    rd(6'h04, d); chk("R9 kbd intact", d, 8'h3C);
    rd(6'h10, d); chk("R10 sticky intact", d, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule